// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Redundancy Correction

This block is the digital back end of a 12-bit pipelined analog-to-digital converter. Four front stages each hand over a raw 3-bit decision code. A final flash stage supplies a 4-bit code. Each stage works on a given input sample one clock after the stage before it, so the five codes that belong to one sample reach this block spread over five consecutive clocks.

The block holds each earlier code in a shift register of suitable length so that all five codes of one sample meet in the same cycle. It then adds them with weights that overlap by one bit between neighbouring stages. The interstage gain is four, so only two of each stage's three bits are effective, and the spare bit absorbs comparator decision errors. A fixed offset removes the mid-range bias that the redundant bits introduce. The result is clamped into the 12-bit range and registered.

A new sample is accepted on every clock. The input valid flag travels through a delay of the same length, so the output valid flag marks each corrected word.

Top module: `pipe_adc_align`

## Requirements
- R1: While rst_n is low, out_word is 0 and out_valid is 0.
- R2: The codes of one sample are presented as follows. Stage k (k = 1..4) is presented k-1 clocks after the clock in which in_valid for that sample is sampled, and the flash code 4 clocks after it. The corrected word for that sample appears on out_word one clock after its flash code is sampled, which is five rising edges after its in_valid edge.
- R3: stg_code packs stage k in bits [3k-1:3k-3], so stage 1 is in bits [2:0]. Stage k is weighted by a left shift of 9, 7, 5 and 3 for k = 1..4, and the flash code has weight 1.
- R4: The constant 680 (512+128+32+8) is subtracted from the weighted sum. For example, every stage code 1 with flash code 5 gives 5.
- R5: A weighted sum below 680 gives out_word = 0. For example, all codes 0 gives 0, and a sum of 679 gives 0.
- R6: Results above 4095 are clamped to 4095. Every stage code 7 with flash code 15 gives exactly 4095.
- R7: A new sample may enter on every clock with no gap, and each of these samples yields its own correct word.
- R8: out_valid equals in_valid delayed by five rising edges. It stays low after reset until the first valid sample has passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the cycle in which stage 1 presents a new sample |
| stg_code | input | 12 | Raw 3-bit codes of stages 1..4, stage 1 in the low bits |
| flash_code | input | 4 | Code of the final flash stage |
| out_word | output | 12 | Corrected, clamped output word |
| out_valid | output | 1 | out_word holds a corrected sample |

## Verification
A delay register of the wrong length for any stage mixes codes from neighbouring samples. Under random stimulus this corrupts the word five edges after the affected sample enters. A wrong shift or offset shows up on the first word whose stage codes are nonzero, and directed samples place that word at the very start of the run. A broken clamp shows only on the all-zero and just-below-offset samples. An error in the valid delay shows on the first valid sample, since the valid pattern is irregular.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int NSTG_D  = 4;   // front stages
    localparam int SBITS_D = 3;   // raw bits per front stage
    localparam int FBITS_D = 4;   // flash bits
    localparam int OBITS_D = 12;  // output word width
endpackage

// File: rtl/pa_skew.sv
module pa_skew #(
    parameter int W     = 3,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CW = $clog2(DEPTH + 1) + 1;

    logic [W-1:0] pipe [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[DEPTH-1];

    // cycles since reset, saturating, for the assertion window
    logic [CW-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         since_rst <= '0;
        else if (since_rst < CW'(DEPTH))    since_rst <= since_rst + 1'b1;
    end

    a_r2_skew_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CW'(DEPTH)) |-> (dout == $past(din, DEPTH)));
endmodule

// File: rtl/pa_merge.sv
module pa_merge #(
    parameter int NSTG  = 4,
    parameter int SBITS = 3,
    parameter int FBITS = 4,
    parameter int OBITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSTG*SBITS-1:0] codes,
    input  logic [FBITS-1:0]      fcode,
    output logic [OBITS-1:0]      word
);
    localparam int EB = SBITS - 1;  // effective bits per stage

    function automatic int stage_shift(input int k);
        return (FBITS - 1) + EB * (NSTG - 1 - k);
    endfunction

    function automatic int calc_offset();
        int s;
        s = 0;
        for (int k = 0; k < NSTG; k++) s += (1 << stage_shift(k));
        return s;
    endfunction

    localparam int OFFSET = calc_offset();
    localparam int MAXV   = (1 << OBITS) - 1;

    int   acc;
    logic under, over;
    logic [OBITS-1:0] word_d;

    always_comb begin
        acc = int'(fcode);
        for (int k = 0; k < NSTG; k++)
            acc = acc + (int'(codes[k*SBITS +: SBITS]) << stage_shift(k));
        acc   = acc - OFFSET;
        under = (acc < 0);
        over  = (acc > MAXV);
        if (under)     word_d = '0;
        else if (over) word_d = '1;
        else           word_d = acc[OBITS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word <= '0;
        else        word <= word_d;
    end

    a_r5_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        under |=> (word == '0));
    a_r6_overflow_sat: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> (word == '1));
endmodule

// File: rtl/pipe_adc_align.sv
module pipe_adc_align
    import pa_pkg::*;
#(
    parameter int NSTG  = NSTG_D,
    parameter int SBITS = SBITS_D,
    parameter int FBITS = FBITS_D,
    parameter int OBITS = OBITS_D
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [NSTG*SBITS-1:0] stg_code,
    input  logic [FBITS-1:0]      flash_code,
    output logic [OBITS-1:0]      out_word,
    output logic                  out_valid
);
    localparam int LAT = NSTG + 1;
    localparam int CW  = $clog2(LAT + 1) + 1;

    logic [NSTG*SBITS-1:0] aligned;
    logic                  vld_aligned;

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        pa_skew #(.W(SBITS), .DEPTH(NSTG - k)) u_skew (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (stg_code[k*SBITS +: SBITS]),
            .dout (aligned[k*SBITS +: SBITS])
        );
    end

    pa_skew #(.W(1), .DEPTH(NSTG)) u_vskew (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_valid),
        .dout (vld_aligned)
    );

    pa_merge #(.NSTG(NSTG), .SBITS(SBITS), .FBITS(FBITS), .OBITS(OBITS)) u_merge (
        .clk  (clk),
        .rst_n(rst_n),
        .codes(aligned),
        .fcode(flash_code),
        .word (out_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= vld_aligned;
    end

    logic [CW-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    since_rst <= '0;
        else if (since_rst < CW'(LAT)) since_rst <= since_rst + 1'b1;
    end

    a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(LAT)) |-> !out_valid);
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_word == '0));
endmodule

// File: tb/pipe_adc_align_tb.sv
module pipe_adc_align_tb;
    localparam int N = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] stg_code = '0;
    logic [3:0]  flash_code = '0;
    logic [11:0] out_word;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;

    int sc [N][4];
    int fc [N];
    int vv [N];

    always #10 clk = ~clk;  // 50 MHz

    pipe_adc_align u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .stg_code(stg_code), .flash_code(flash_code),
        .out_word(out_word), .out_valid(out_valid)
    );

    function automatic int ref_word(input int s);
        int v;
        v = sc[s][0]*512 + sc[s][1]*128 + sc[s][2]*32 + sc[s][3]*8 + fc[s] - 680;
        if (v < 0)    v = 0;
        if (v > 4095) v = 4095;
        return v;
    endfunction

    task automatic chk(input int got, input int exp, input string req);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic string tag_of(input int s);
        case (s)
            0: return "R5 zero codes";
            1: return "R6 full scale";
            2: return "R4 offset";
            3: return "R5 sum 679";
            4: return "R3 midscale";
            default: return "R2/R7 random";
        endcase
    endfunction

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) begin
            vv[i] = ($urandom % 4 != 0) ? 1 : 0;
            for (int k = 0; k < 4; k++) sc[i][k] = int'($urandom % 8);
            fc[i] = int'($urandom % 16);
        end
        // directed corners, back to back (R7)
        for (int k = 0; k < 4; k++) begin
            sc[0][k] = 0; sc[1][k] = 7; sc[2][k] = 1; sc[3][k] = 1; sc[4][k] = 4;
        end
        fc[0] = 0; fc[1] = 15; fc[2] = 5; fc[4] = 8;
        sc[3][3] = 0; fc[3] = 7;   // 512+128+32+7 = 679
        for (int i = 0; i < 5; i++) vv[i] = 1;
        vv[5] = 0; vv[6] = 1; vv[7] = 0; vv[8] = 0; vv[9] = 1;

        repeat (3) @(posedge clk);
        #1;
        chk(int'(out_word), 0, "R1 word in reset");
        chk(int'(out_valid), 0, "R1 valid in reset");

        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < N + 5; t++) begin
            @(negedge clk);
            in_valid = (t < N) ? vv[t][0] : 1'b0;
            for (int k = 0; k < 4; k++) begin
                int idx;
                idx = t - k;
                stg_code[k*3 +: 3] = (idx >= 0 && idx < N) ? sc[idx][k][2:0] : 3'd0;
            end
            flash_code = (t - 4 >= 0 && t - 4 < N) ? fc[t-4][3:0] : 4'd0;
            @(posedge clk);
            #1;
            begin
                int s;
                s = t - 4;
                if (s < 0) begin
                    chk(int'(out_word), 0, "R2 fill word");
                    chk(int'(out_valid), 0, "R8 quiet after reset");
                end else if (s < N) begin
                    chk(int'(out_word), ref_word(s), tag_of(s));
                    chk(int'(out_valid), vv[s], "R8 valid delay");
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule